// File: doc/BRIEF.md
# Programmable Clock Divider with Settling Flag

This block divides a reference clock by a programmable ratio. It is built for a clock control unit. Software drives it through one 32-bit control word with a write strobe and a continuous read port. The word carries:

- an output enable,
- a one-shot request for a fixed-length pulse on the reset domain,
- a one-shot strobe that applies a new ratio,
- the ratio field,
- an active-high gate for the buffered reference output,
- a read-only settled flag.

Writing the ratio field stores it but does not apply it. The ratio is applied only when the apply strobe is set in the same write. Applying a ratio restarts the divider from the start of its high phase and clears the settled flag. The flag rises again a fixed number of reference cycles later and stays high. Ratios 0 and 1 both pass the reference clock straight through.

Top module: `clkdiv_lock`

## Requirements
- R1: After reset the read word is zero except for the settled flag, which reads 1. `clk_o` and `dom_rst_o` are low, and `ref_buf_o` follows the reference clock.
- R2: The control word has these fields:
  - Bit 0 is the enable and reads back as written.
  - The ratio field sits at bits 4 upward, `DIV_W` bits wide, and reads back as written.
  - Bit 28 is the buffer gate and reads back as written.
  - Bit 2 is the apply strobe and always reads 0.
- R3: A write that changes the ratio field without bit 2 set leaves the output ratio and the settled flag unchanged.
- R4: A write with bit 2 set at clock edge W applies ratio N = max(field, 1). For N ≥ 2, when sampled after edge W+j, `clk_o` is 1 exactly when j ≥ 1 and ((j−1) mod N) < floor(N/2). An odd N therefore has a high phase one cycle shorter than its low phase.
- R5: With ratio 0 or 1 applied and enable set, `clk_o` equals the reference clock, high in its high phase and low in its low phase.
- R6: The settled flag behaves as follows around an apply strobe at edge W:
  - It reads 0 after edges W through W+2N−1.
  - It reads 1 from edge W+2N on, which is within 4·N cycles.
  - It then holds 1 until the next apply strobe.
- R7: The settled flag is read at bit 31. With `LOCK_AT_27` = 1 it is read at bit 27 instead, and bit 31 reads 0.
- R8: While bit 0 is 0, `clk_o` is held low, including in pass-through. When bit 0 is set again at edge W, the divider restarts with the R4 pattern counted from W.
- R9: When bit 28 is 1, `ref_buf_o` is held low. When bit 28 is 0, `ref_buf_o` follows the reference clock.
- R10: A write with bit 1 set at edge W drives `dom_rst_o` high from edge W for exactly `RST_CYC` cycles. Bit 1 reads 1 only while the pulse is active. The default `RST_CYC` is chosen so that the pulse fits within 1 µs at the nominal reference rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Control word write strobe |
| reg_wdata_i | input | 32 | Control word write data |
| reg_rdata_o | output | 32 | Control word read data |
| clk_o | output | 1 | Divided clock |
| ref_buf_o | output | 1 | Gated buffered reference clock |
| dom_rst_o | output | 1 | Reset-domain pulse |

## Verification
The bench builds the main instance with a 4-bit ratio field and an 8-cycle reset pulse. This makes it practical to sweep every field value from 0 to 15. For each value, the output pattern and the settled-flag window are checked cycle by cycle against arithmetic expectations over two full settling windows. A second instance is built with `LOCK_AT_27` = 1 and receives the same writes, so both placements of the settled flag are checked against one stimulus stream. The small field keeps the longest settling window at 30 cycles, which leaves room for the enable, pass-through, buffer-gate and reset-pulse scenarios.

// File: rtl/clkdiv_lock_pkg.sv
`timescale 1ns/1ps
package clkdiv_lock_pkg;
  localparam int unsigned BIT_EN      = 0;
  localparam int unsigned BIT_RST     = 1;
  localparam int unsigned BIT_LOAD    = 2;
  localparam int unsigned DIV_LSB     = 4;
  localparam int unsigned BIT_BUFGATE = 28;
  localparam int unsigned BIT_LOCK_HI = 31;
  localparam int unsigned BIT_LOCK_LO = 27;

  typedef struct packed {
    logic en;
    logic buf_gate;
  } ctl_state_t;
endpackage

// File: rtl/clkdiv_cg.sv
`timescale 1ns/1ps
module clkdiv_cg #(
  parameter bit INIT = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic gclk_o
);
  logic en_l;

  // enable captured in the low phase so the AND never chops a high pulse
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_l <= INIT;
    else         en_l <= en_i;
  end

  assign gclk_o = clk_i & en_l;
endmodule

// File: rtl/clkdiv_ctl.sv
`timescale 1ns/1ps
module clkdiv_ctl
  import clkdiv_lock_pkg::*;
#(
  parameter int unsigned DIV_W      = 8,
  parameter bit          LOCK_AT_27 = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [31:0]      wdata_i,
  input  logic             lock_i,
  input  logic             busy_i,
  output ctl_state_t       st_o,
  output logic             load_o,
  output logic             rst_req_o,
  output logic [DIV_W-1:0] load_div_o,
  output logic [31:0]      rdata_o
);
  localparam int unsigned LOCK_BIT = LOCK_AT_27 ? BIT_LOCK_LO : BIT_LOCK_HI;
  localparam logic [31:0] FIELD_MASK = ((32'd1 << DIV_W) - 32'd1) << DIV_LSB;
  localparam logic [31:0] USED_MASK  = FIELD_MASK | (32'd1 << BIT_EN) | (32'd1 << BIT_RST)
                                     | (32'd1 << BIT_LOAD) | (32'd1 << BIT_BUFGATE);

  ctl_state_t       st_q;
  logic [DIV_W-1:0] field_q;
  logic             unused_wdata;

  assign unused_wdata = ^(wdata_i & ~USED_MASK);
  assign load_div_o   = wdata_i[DIV_LSB +: DIV_W];
  assign load_o       = we_i & wdata_i[BIT_LOAD];
  assign rst_req_o    = we_i & wdata_i[BIT_RST];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= '0;
      field_q <= '0;
    end else if (we_i) begin
      st_q.en       <= wdata_i[BIT_EN];
      st_q.buf_gate <= wdata_i[BIT_BUFGATE];
      field_q       <= wdata_i[DIV_LSB +: DIV_W];
    end
  end

  assign st_o = st_q;

  always_comb begin
    rdata_o                     = '0;
    rdata_o[BIT_EN]             = st_q.en;
    rdata_o[BIT_RST]            = busy_i;
    rdata_o[DIV_LSB +: DIV_W]   = field_q;
    rdata_o[BIT_BUFGATE]        = st_q.buf_gate;
    rdata_o[LOCK_BIT]           = lock_i;
  end

  // strobes are one-shot: the held state never remembers them
  assert_strobe_reads_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (rdata_o[BIT_LOAD] == 1'b0));
endmodule

// File: rtl/clkdiv_ratio.sv
`timescale 1ns/1ps
module clkdiv_ratio #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             load_i,
  input  logic [DIV_W-1:0] load_div_i,
  output logic [DIV_W-1:0] act_div_o,
  output logic             clk_o
);
  logic [DIV_W-1:0] act_div_q, cnt_q, eff, half;
  logic             div_q, bypass, gclk;

  assign eff    = (act_div_q == '0) ? DIV_W'(1) : act_div_q;
  assign half   = eff >> 1;
  assign bypass = (act_div_q <= DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_div_q <= '0;
      cnt_q     <= '0;
      div_q     <= 1'b0;
    end else if (load_i) begin
      act_div_q <= load_div_i;
      cnt_q     <= '0;
      div_q     <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      div_q <= 1'b0;
    end else begin
      div_q <= (cnt_q < half);
      cnt_q <= (cnt_q == eff - DIV_W'(1)) ? '0 : cnt_q + DIV_W'(1);
    end
  end

  clkdiv_cg #(.INIT(1'b0)) u_out_cg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i & bypass),
    .gclk_o (gclk)
  );

  assign clk_o     = bypass ? gclk : div_q;
  assign act_div_o = act_div_q;

  assert_hold_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !div_q);
  assert_ratio_kept_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(act_div_q));
endmodule

// File: rtl/clkdiv_lock_tmr.sv
`timescale 1ns/1ps
module clkdiv_lock_tmr #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DIV_W-1:0] act_div_i,
  output logic             lock_o
);
  localparam int unsigned TW = DIV_W + 2;

  logic [DIV_W-1:0] eff;
  logic [TW-1:0]    lim, tmr_q;
  logic             lock_q;

  assign eff = (act_div_i == '0) ? DIV_W'(1) : act_div_i;
  assign lim = {1'b0, eff, 1'b0} - TW'(1);   // two output periods

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q  <= '0;
      lock_q <= 1'b1;
    end else if (load_i) begin
      tmr_q  <= '0;
      lock_q <= 1'b0;
    end else if (!lock_q) begin
      if (tmr_q == lim) lock_q <= 1'b1;
      else              tmr_q  <= tmr_q + TW'(1);
    end
  end

  assign lock_o = lock_q;

  assert_lock_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !lock_o);
  assert_lock_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_o && !load_i) |=> lock_o);
  assert_lock_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_o |-> (tmr_q <= lim));
endmodule

// File: rtl/clkdiv_rst_pulse.sv
`timescale 1ns/1ps
module clkdiv_rst_pulse #(
  parameter int unsigned RST_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(RST_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (req_i) begin
      cnt_q  <= CW'(RST_CYC - 1);
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - CW'(1);
    end
  end

  assign busy_o = busy_q;

  assert_pulse_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(req_i));
  assert_pulse_len_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q < CW'(RST_CYC)));
endmodule

// File: rtl/clkdiv_lock.sv
`timescale 1ns/1ps
module clkdiv_lock
  import clkdiv_lock_pkg::*;
#(
  parameter int unsigned DIV_W      = 8,
  parameter bit          LOCK_AT_27 = 1'b0,
  parameter int unsigned RST_CYC    = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        clk_o,
  output logic        ref_buf_o,
  output logic        dom_rst_o
);
  ctl_state_t       st;
  logic             load, rst_req, lock, busy;
  logic [DIV_W-1:0] load_div, act_div;

  clkdiv_ctl #(.DIV_W(DIV_W), .LOCK_AT_27(LOCK_AT_27)) u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .wdata_i    (reg_wdata_i),
    .lock_i     (lock),
    .busy_i     (busy),
    .st_o       (st),
    .load_o     (load),
    .rst_req_o  (rst_req),
    .load_div_o (load_div),
    .rdata_o    (reg_rdata_o)
  );

  clkdiv_ratio #(.DIV_W(DIV_W)) u_ratio (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (st.en),
    .load_i     (load),
    .load_div_i (load_div),
    .act_div_o  (act_div),
    .clk_o      (clk_o)
  );

  clkdiv_lock_tmr #(.DIV_W(DIV_W)) u_lock (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .act_div_i (act_div),
    .lock_o    (lock)
  );

  clkdiv_rst_pulse #(.RST_CYC(RST_CYC)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (rst_req),
    .busy_o (busy)
  );

  clkdiv_cg #(.INIT(1'b1)) u_buf_cg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (~st.buf_gate),
    .gclk_o (ref_buf_o)
  );

  assign dom_rst_o = busy;
endmodule

// File: tb/clkdiv_lock_tb.sv
`timescale 1ns/1ps
module clkdiv_lock_tb;
  localparam int DW = 4;
  localparam int RC = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [31:0] wd = '0;
  logic [31:0] rd, rd_alt;
  logic        co, rbuf, drst, co_alt, rbuf_alt, drst_alt;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  clkdiv_lock #(.DIV_W(DW), .LOCK_AT_27(1'b0), .RST_CYC(RC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_wdata_i(wd),
    .reg_rdata_o(rd), .clk_o(co), .ref_buf_o(rbuf), .dom_rst_o(drst));

  clkdiv_lock #(.DIV_W(DW), .LOCK_AT_27(1'b1), .RST_CYC(RC)) u_alt (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_wdata_i(wd),
    .reg_rdata_o(rd_alt), .clk_o(co_alt), .ref_buf_o(rbuf_alt), .dom_rst_o(drst_alt));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic wr(input logic [31:0] d);
    we = 1'b1; wd = d;
    step();
    we = 1'b0;
  endtask

  function automatic logic exp_out(input int n, input int j);
    return (j >= 1) && (((j - 1) % n) < (n / 2));
  endfunction

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step(); step();
    // R1 reset state
    chk("R1 rdata", rd, 32'h8000_0000);
    chk("R1 clk_o", {31'd0, co}, 0);
    chk("R1 dom_rst", {31'd0, drst}, 0);
    chk("R1 ref_buf", {31'd0, rbuf}, 1);
    chk("R7 alt rdata", rd_alt, 32'h0800_0000);

    wr(32'h1);
    chk("R2 enable readback", {31'd0, rd[0]}, 1);

    // R4 R5 R6: sweep every field value
    for (int v = 0; v < 16; v++) begin
      int n;
      n = (v == 0) ? 1 : v;
      wr(32'h5 | (v << 4));
      chk("R2 field readback", {28'd0, rd[7:4]}, v);
      chk("R2 strobe reads 0", {31'd0, rd[2]}, 0);
      chk("R7 alt lock low", {30'd0, rd_alt[31], rd_alt[27]}, 0);
      for (int j = 0; j <= 4 * n; j++) begin
        chk("R6 lock window", {31'd0, rd[31]}, (j >= 2 * n) ? 1 : 0);
        if (n == 1) begin
          if (j >= 1) chk("R5 pass high phase", {31'd0, co}, 1);
        end else begin
          chk("R4 output pattern", {31'd0, co}, exp_out(n, j));
        end
        if (j == 2 * n) chk("R7 alt lock bit27", {30'd0, rd_alt[31], rd_alt[27]}, 1);
        step();
      end
    end

    // R3 field-only write keeps ratio 3
    wr(32'h5 | (3 << 4));
    repeat (8) step();
    wr(32'h1 | (5 << 4));
    chk("R3 field readback", {28'd0, rd[7:4]}, 5);
    begin
      int highs = 0;
      for (int j = 0; j < 30; j++) begin
        highs += co;
        step();
      end
      chk("R3 ratio unchanged", highs, 10);
    end
    chk("R3 lock kept", {31'd0, rd[31]}, 1);

    // R8 enable low holds output, restart on re-enable
    wr(32'h0 | (3 << 4));
    for (int j = 1; j <= 10; j++) begin
      step();
      chk("R8 held low", {31'd0, co}, 0);
    end
    wr(32'h1 | (3 << 4));
    for (int j = 0; j < 9; j++) begin
      chk("R8 restart pattern", {31'd0, co}, exp_out(3, j));
      step();
    end

    // R5 low phase in pass-through, R8 in pass-through
    wr(32'h5 | (1 << 4));
    repeat (3) step();
    @(negedge clk); #1;
    chk("R5 pass low phase", {31'd0, co}, 0);
    step();
    chk("R5 pass high phase", {31'd0, co}, 1);
    wr(32'h0 | (1 << 4));
    step(); step();
    chk("R8 pass-through gated", {31'd0, co}, 0);
    wr(32'h1 | (1 << 4));
    step(); step();
    chk("R8 pass-through resumed", {31'd0, co}, 1);

    // R9 buffer gate
    wr(32'h1 | (1 << 4) | (32'd1 << 28));
    step();
    chk("R9 gate readback", {31'd0, rd[28]}, 1);
    chk("R9 buffer gated", {31'd0, rbuf}, 0);
    wr(32'h1 | (1 << 4));
    step();
    chk("R9 buffer on", {31'd0, rbuf}, 1);
    @(negedge clk); #1;
    chk("R9 buffer low phase", {31'd0, rbuf}, 0);
    step();

    // R10 reset-domain pulse
    wr(32'h3 | (1 << 4));
    for (int j = 0; j <= RC; j++) begin
      chk("R10 pulse", {31'd0, drst}, (j < RC) ? 1 : 0);
      chk("R10 busy readback", {31'd0, rd[1]}, (j < RC) ? 1 : 0);
      step();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule